// File: doc/BRIEF.md
# Single-Cycle Two-Register Processor Core

This block is a 16-bit processor that completes one instruction on every clock, with no pipeline. It holds an address/constant register (A), a data register (D) and a program counter. Instructions are fetched from an external instruction ROM addressed by the program counter. Data is exchanged with an external data RAM.

Each instruction word does one of two things. If it has a clear top bit, it loads a 15-bit constant into A. If the top bit is set, it is a compute word, which does three things:
- It selects an ALU function of D and either A or the RAM word addressed by A.
- It routes the result to any mix of A, D and RAM.
- It optionally jumps to the address held in A, depending on the sign and zero status of the result.

The RAM read address is a registered copy of A, so a read reflects the value A held one instruction earlier. Software must place a no-op word (0x8A00) between a change of A and a read of memory. Writes use the current A directly.

Top module: `hk_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter, A, D and the registered read address to zero.
- R2: A word with bit 15 = 0 loads `{0, instr[14:0]}` into A, leaves D and RAM untouched, and advances the program counter by one.
- R3: In a compute word, the ALU takes x = D. It takes y = A when bit 12 = 0, or y = the RAM read data when bit 12 = 1. Bits 11..6 are, from high to low: zero x, invert x, zero y, invert y, add (1) or AND (0), invert result. For example, 0x9C10 gives D = memory and 0x84C8 writes D − A.
- R4: Destination bit 5 writes A, bit 4 writes D and bit 3 writes RAM. All selected destinations take the same ALU result in the same cycle. The RAM write address is the value of A before this instruction.
- R5: The jump bits test the signed ALU result: bit 0 less than zero, bit 1 equal to zero, bit 2 greater than zero. If any selected test holds, the program counter loads the value of A before this instruction; otherwise it advances by one.
- R6: The RAM read address in a cycle equals A as it stood in the previous cycle. An instruction that reads memory right after A changes sees the old address.
- R7: The compute word 0x8A00 changes neither A, D nor RAM and advances the program counter by one.
- R8: A multiply-by-repeated-addition factorial program written for this core stores 7! = 5040 in RAM word 0 and then loops at its halt address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | IADDR_W | Instruction fetch address (program counter) |
| imem_data | input | 16 | Instruction word at imem_addr |
| dmem_addr | output | DADDR_W | Current A, used as the RAM write address |
| dmem_raddr | output | DADDR_W | Registered read address (A of the previous cycle) |
| dmem_rdata | input | 16 | RAM word at dmem_raddr, read asynchronously |
| dmem_we | output | 1 | RAM write enable |
| dmem_wdata | output | 16 | RAM write data (ALU result) |

## Verification
The assertions assume the instruction word is a known value in every cycle outside reset, and that the RAM returns the word at `dmem_raddr` within the same cycle. The bench drives a fixed no-op during reset. It then feeds either a directed word sequence or the program ROM indexed by the fetch address, so the instruction input is never left undriven. The RAM model is an asynchronous-read array that the bench preloads while reset is held. Every program placed in it inserts the required no-op after a change of A, except one deliberate hazard step that shows the stale read.

// File: rtl/hk_pkg.sv
package hk_pkg;
  localparam int WORD_W   = 16;
  localparam int OPC_BIT  = WORD_W - 1;
  localparam int MSEL_BIT = 12;
  localparam int FN_LSB   = 6;
  localparam int FN_W     = 6;
  localparam int DST_LSB  = 3;
  localparam int DST_W    = 3;
  localparam int JMP_LSB  = 0;
  localparam int JMP_W    = 3;
  localparam int IMM_W    = WORD_W - 1;

  // ALU control, ordered high to low as in the instruction word
  typedef struct packed {
    logic zx;
    logic nx;
    logic zy;
    logic ny;
    logic fadd;
    logic nout;
  } alu_fn_t;

  typedef struct packed {
    logic wa;
    logic wd;
    logic wm;
  } dest_t;

  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } jcond_t;

  typedef struct packed {
    logic             compute;
    logic             mem_op;
    alu_fn_t          fn;
    dest_t            dst;
    jcond_t           jmp;
    logic [IMM_W-1:0] imm;
  } ctl_t;
endpackage

// File: rtl/hk_decode.sv
module hk_decode
  import hk_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  output ctl_t              ctl
);
  logic is_comp;

  assign is_comp = instr[OPC_BIT];

  always_comb begin
    ctl.compute = is_comp;
    ctl.mem_op  = is_comp & instr[MSEL_BIT];
    ctl.fn      = alu_fn_t'(instr[FN_LSB +: FN_W]);
    ctl.dst     = is_comp ? dest_t'(instr[DST_LSB +: DST_W]) : '0;
    ctl.jmp     = is_comp ? jcond_t'(instr[JMP_LSB +: JMP_W]) : '0;
    ctl.imm     = instr[IMM_W-1:0];
  end
endmodule

// File: rtl/hk_alu.sv
module hk_alu
  import hk_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  alu_fn_t      fn,
  output logic [W-1:0] res,
  output logic         neg,
  output logic         zero
);
  logic [W-1:0] xz, xn, yz, yn, core;

  always_comb begin
    xz   = fn.zx ? '0 : x;
    xn   = fn.nx ? ~xz : xz;
    yz   = fn.zy ? '0 : y;
    yn   = fn.ny ? ~yz : yz;
    core = fn.fadd ? (xn + yn) : (xn & yn);
    res  = fn.nout ? ~core : core;
  end

  assign neg  = res[W-1];
  assign zero = (res == '0);
endmodule

// File: rtl/hk_branch.sv
module hk_branch
  import hk_pkg::*;
#(
  parameter int IADDR_W = 15
) (
  input  logic               compute,
  input  jcond_t             jmp,
  input  logic               neg,
  input  logic               zero,
  input  logic [IADDR_W-1:0] pc,
  input  logic [IADDR_W-1:0] target,
  output logic [IADDR_W-1:0] pc_next,
  output logic               taken
);
  logic pos;

  assign pos   = ~neg & ~zero;
  assign taken = compute & ((jmp.lt & neg) | (jmp.eq & zero) | (jmp.gt & pos));
  assign pc_next = taken ? target : pc + IADDR_W'(1);
endmodule

// File: rtl/hk_core.sv
module hk_core
  import hk_pkg::*;
#(
  parameter int IADDR_W = 15,
  parameter int DADDR_W = 15
) (
  input  logic               clk,
  input  logic               rst,
  output logic [IADDR_W-1:0] imem_addr,
  input  logic [WORD_W-1:0]  imem_data,
  output logic [DADDR_W-1:0] dmem_addr,
  output logic [DADDR_W-1:0] dmem_raddr,
  input  logic [WORD_W-1:0]  dmem_rdata,
  output logic               dmem_we,
  output logic [WORD_W-1:0]  dmem_wdata
);
  localparam int IMM_PAD = WORD_W - IMM_W;

  ctl_t               ctl;
  logic [IADDR_W-1:0] pc_q, pc_next;
  logic [WORD_W-1:0]  a_q, d_q, a_nxt, y_opnd, alu_res;
  logic [DADDR_W-1:0] raddr_q;
  logic               load_a, alu_neg, alu_zero, jump_taken;

  hk_decode u_dec (
    .instr(imem_data),
    .ctl  (ctl)
  );

  assign y_opnd = ctl.mem_op ? dmem_rdata : a_q;

  hk_alu #(.W(WORD_W)) u_alu (
    .x   (d_q),
    .y   (y_opnd),
    .fn  (ctl.fn),
    .res (alu_res),
    .neg (alu_neg),
    .zero(alu_zero)
  );

  hk_branch #(.IADDR_W(IADDR_W)) u_br (
    .compute(ctl.compute),
    .jmp    (ctl.jmp),
    .neg    (alu_neg),
    .zero   (alu_zero),
    .pc     (pc_q),
    .target (a_q[IADDR_W-1:0]),
    .pc_next(pc_next),
    .taken  (jump_taken)
  );

  assign load_a = ~ctl.compute | ctl.dst.wa;
  assign a_nxt  = ctl.compute ? alu_res : {{IMM_PAD{1'b0}}, ctl.imm};

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      a_q     <= '0;
      d_q     <= '0;
      raddr_q <= '0;
    end else begin
      pc_q    <= pc_next;
      raddr_q <= a_q[DADDR_W-1:0];
      if (load_a)     a_q <= a_nxt;
      if (ctl.dst.wd) d_q <= alu_res;
    end
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = a_q[DADDR_W-1:0];
  assign dmem_raddr = raddr_q;
  assign dmem_we    = ctl.dst.wm & ~rst;
  assign dmem_wdata = alu_res;

  // R1: reset clears the architectural state
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (pc_q == '0 && a_q == '0 && d_q == '0 && raddr_q == '0));

  // R2: constant word loads A and steps the program counter
  assert_const_load_R2: assert property (@(posedge clk) disable iff (rst)
    !imem_data[OPC_BIT] |=>
      (a_q == {{IMM_PAD{1'b0}}, $past(imem_data[IMM_W-1:0])}
       && pc_q == $past(pc_q) + IADDR_W'(1)));

  // R5: unconditional jump lands on the old A
  assert_uncond_jump_R5: assert property (@(posedge clk) disable iff (rst)
    (imem_data[OPC_BIT] && imem_data[JMP_LSB +: JMP_W] == 3'b111) |=>
      pc_q == $past(a_q[IADDR_W-1:0]));

  // R6: read address lags A by one cycle
  assert_raddr_lag_R6: assert property (@(posedge clk) disable iff (rst)
    !rst |=> dmem_raddr == $past(a_q[DADDR_W-1:0]));

  // R7: a compute word without destinations keeps A and D
  assert_nodest_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (imem_data[OPC_BIT] && imem_data[DST_LSB +: DST_W] == 3'b000) |=>
      ($stable(a_q) && $stable(d_q)));

  // R4: no RAM write from a constant word
  assert_const_no_write_R4: assert property (@(posedge clk) disable iff (rst)
    !imem_data[OPC_BIT] |-> !dmem_we);
endmodule

// File: tb/test_hk_core.sv
`timescale 1ns/1ps
module test_hk_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [14:0] imem_addr, dmem_addr, dmem_raddr;
  logic [15:0] imem_data, dmem_rdata, dmem_wdata;
  logic        dmem_we;
  logic [15:0] instr_r = 16'h8A00;
  logic        use_rom = 1'b0;
  logic        ram_init = 1'b0;
  logic [15:0] rom [0:63];
  logic [15:0] ram [0:255];
  int          total = 0;
  int          bad = 0;
  logic [14:0] prev_addr = '0;

  typedef struct {
    string       tag;
    logic [14:0] pc;
    logic [14:0] addr;
    logic [14:0] raddr;
    logic        we;
    logic [15:0] wdata;
  } item_t;
  item_t exp_q[$];

  always #5 clk = ~clk;

  hk_core i_hk_core (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_raddr(dmem_raddr), .dmem_rdata(dmem_rdata),
    .dmem_we(dmem_we), .dmem_wdata(dmem_wdata)
  );

  assign imem_data  = use_rom ? rom[imem_addr[5:0]] : instr_r;
  assign dmem_rdata = ram[dmem_raddr[7:0]];

  always @(posedge clk) begin
    if (ram_init) begin
      for (int i = 0; i < 256; i++) ram[i] <= 16'h0000;
      ram[5] <= 16'h0123;
      ram[6] <= 16'hFFFE;
    end else if (dmem_we) begin
      ram[dmem_addr[7:0]] <= dmem_wdata;
    end
  end

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pops one expected item per cycle and compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        check(it.tag, "pc", {1'b0, imem_addr}, {1'b0, it.pc});
        check(it.tag, "addr", {1'b0, dmem_addr}, {1'b0, it.addr});
        check(it.tag, "raddr", {1'b0, dmem_raddr}, {1'b0, it.raddr});
        check(it.tag, "we", {15'd0, dmem_we}, {15'd0, it.we});
        if (it.we) check(it.tag, "wdata", dmem_wdata, it.wdata);
      end
    end
  end

  // driver: applies one word and queues what the ports must show this cycle
  task automatic step(string tag, logic [15:0] ins, int pc, int addr,
                      bit we, logic [15:0] wd);
    item_t it;
    it.tag   = tag;
    it.pc    = 15'(pc);
    it.addr  = 15'(addr);
    it.raddr = prev_addr;   // R6: read address is last cycle's A
    it.we    = we;
    it.wdata = wd;
    prev_addr = 15'(addr);
    instr_r = ins;
    exp_q.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic do_reset(bit rom_mode);
    rst = 1'b1; ram_init = 1'b1; use_rom = rom_mode; instr_r = 16'h8A00;
    repeat (3) @(posedge clk);
    #1; rst = 1'b0; ram_init = 1'b0; prev_addr = '0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) rom[i] = 16'h8A00;
    // factorial of 7 by repeated addition; RAM: 0 result, 1 k, 2 acc, 3 j
    rom[0]  = 16'h0000; rom[1]  = 16'h8FC8; rom[2]  = 16'h0007; rom[3]  = 16'h8C10;
    rom[4]  = 16'h0001; rom[5]  = 16'h8308; rom[6]  = 16'h0001; rom[7]  = 16'h8A00;
    rom[8]  = 16'h9C10; rom[9]  = 16'h8390; rom[10] = 16'h0028; rom[11] = 16'h8303;
    rom[12] = 16'h0002; rom[13] = 16'h8A88; rom[14] = 16'h0001; rom[15] = 16'h8A00;
    rom[16] = 16'h9C10; rom[17] = 16'h0003; rom[18] = 16'h8308; rom[19] = 16'h0000;
    rom[20] = 16'h8A00; rom[21] = 16'h9C10; rom[22] = 16'h0002; rom[23] = 16'h8A00;
    rom[24] = 16'h9088; rom[25] = 16'h0003; rom[26] = 16'h8A00; rom[27] = 16'h9C98;
    rom[28] = 16'h0013; rom[29] = 16'h8304; rom[30] = 16'h0002; rom[31] = 16'h8A00;
    rom[32] = 16'h9C10; rom[33] = 16'h0000; rom[34] = 16'h8308; rom[35] = 16'h0001;
    rom[36] = 16'h8A00; rom[37] = 16'h9C88; rom[38] = 16'h0006; rom[39] = 16'h8A07;
    rom[40] = 16'h0028; rom[41] = 16'h8A07;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    step("R1", 16'h0005, 0, 0, 0, 0);          // reset state; R2 load A=5
    step("R7", 16'h8A00, 1, 5, 0, 0);
    step("R3", 16'h9C10, 2, 5, 0, 0);          // D = mem[5] = 0123
    step("R2", 16'h0007, 3, 5, 0, 0);
    step("R4", 16'h8308, 4, 7, 1, 16'h0123);   // mem[7] = D
    step("R4", 16'h87F0, 5, 7, 0, 0);          // A,D = D+1
    step("R4", 16'h80B8, 6, 16'h124, 1, 16'h0248); // A,D,M = D+A at old A
    step("R4", 16'h8308, 7, 16'h248, 1, 16'h0248);
    step("R2", 16'h0F0F, 8, 16'h248, 0, 0);
    step("R3", 16'h8008, 9, 16'hF0F, 1, 16'h0208);   // D&A
    step("R3", 16'h8548, 10, 16'hF0F, 1, 16'h0F4F);  // D|A
    step("R3", 16'h84C8, 11, 16'hF0F, 1, 16'hF339);  // D-A
    step("R3", 16'h8348, 12, 16'hF0F, 1, 16'hFDB7);  // !D
    step("R3", 16'h8E88, 13, 16'hF0F, 1, 16'hFFFF);  // -1
    step("R2", 16'h0006, 14, 16'hF0F, 0, 0);
    step("R6", 16'h8A00, 15, 6, 0, 0);
    step("R3", 16'h91C8, 16, 6, 1, 16'hFDB6);        // M-D
    step("R2", 16'h0005, 17, 6, 0, 0);
    step("R6", 16'h9DC8, 18, 5, 1, 16'hFDB7);        // stale read of mem[6]
    step("R2", 16'h001E, 19, 5, 0, 0);
    step("R5", 16'h8301, 20, 16'h1E, 0, 0);          // D>0, jump-if-less not taken
    step("R5", 16'h8304, 21, 16'h1E, 0, 0);          // jump-if-greater taken
    step("R5", 16'h8E90, 30, 16'h1E, 0, 0);          // D = -1
    step("R2", 16'h0028, 31, 16'h1E, 0, 0);
    step("R5", 16'h8302, 32, 16'h28, 0, 0);          // not zero
    step("R5", 16'h87C2, 33, 16'h28, 0, 0);          // D+1 == 0 taken
    step("R5", 16'h8FE7, 40, 16'h28, 0, 0);          // A=1, jump to old A
    step("R7", 16'h8A00, 40, 1, 0, 0);
    step("R7", 16'h8308, 41, 1, 1, 16'hFFFF);        // D kept through no-op
    step("R5", 16'h8303, 42, 1, 0, 0);               // negative, jump-if-le
    step("R5", 16'h8A00, 1, 1, 0, 0);
    do_reset(1'b0);
    step("R1", 16'h8308, 0, 0, 1, 16'h0000);         // D cleared by reset
    step("R1", 16'h8A00, 1, 0, 0, 0);

    do_reset(1'b1);
    repeat (2000) @(posedge clk);
    #1;
    check("R8", "result", ram[0], 16'd5040);
    check("R8", "k final", ram[1], 16'd1);
    check("R8", "halt pc", {15'd0, (imem_addr == 15'd40 || imem_addr == 15'd41)}, 16'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule